// File: doc/BRIEF.md
# Tiled Address Channel Swizzler

This block works out which bit-6 address swizzle a tiled surface needs on a dual-channel memory system, and then applies it to byte addresses. When memory is interleaved across two channels, the graphics engine and the CPU decide the channel from different address bits. To let the CPU address a tiled buffer the same way the graphics engine does, address bit 6 is XORed with a set of higher address bits. That set depends on the tiling direction and on the detected interleave configuration.

The block raises a configuration request after reset. A configuration strobe then delivers four inputs together: a memory-configuration word, the top rank boundary of each of the two channels, and a platform class. On the next clock edge the block registers one swizzle mode for X tiling and one for Y tiling. After that, each surface request (tiling mode, stride, address) is resolved combinationally. The outputs are the effective tiling and stride, the physical swizzle mode, a user-visible mode that leaves out the bit-17 term, and the swizzled address.

Top module: `tiled_addr_swizzler`

## Requirements
- R1: After reset `cfg_req` is 1 and both detected modes are UNKNOWN (7), so every tiled request falls back to linear until a configuration arrives.
- R2: The detected modes change only on the clock edge that samples `cfg_valid` high, and then show the decoded inputs. `cfg_req` is 0 from that edge on. Changes to the configuration inputs without the strobe have no effect.
- R3: Platform class 0 (legacy) selects NONE for both X and Y. Platform class 3 (fixed) selects 9_10 for X and 9 for Y, whatever the other inputs are.
- R4: Platform class 1 (mobile) reads the channel mode from configuration bits [1:0]. Code 0 (single) and code 1 (asymmetric dual) select NONE for both directions. Code 3 selects UNKNOWN.
- R5: On platform 1 with channel code 2 (interleaved), the result depends on two flag bits. If bit 10 (channel XOR off) is set, the result is X=9_10 and Y=9. If bit 10 is clear and bit 9 is clear, the result is X=9_10_11 and Y=9_11. If bit 10 is clear and bit 9 is set, the result is X=9_10_17 and Y=9_17.
- R6: On platform 1, a configuration word of all ones selects UNKNOWN for both directions, whatever its field values.
- R7: Platform class 2 (flexible) selects X=9_10 and Y=9 when the two rank boundaries are equal, and NONE for both when they differ.
- R8: Tiling code 0 is linear, 1 is X and 2 is Y; code 3 is treated as linear. A linear request reports effective tiling 0, physical and user modes NONE and stride 0, and the address passes through unchanged.
- R9: An X or Y request whose detected mode is UNKNOWN falls back to effective tiling 0, modes NONE and stride 0.
- R10: An X or Y request with a known mode keeps its tiling and stride, and reports the detected mode as its physical mode. The user-visible mode is the same code, except that 9_17 is reported as 9 and 9_10_17 is reported as 9_10.
- R11: `addr_out` equals `addr_in`, except that bit 6 is XORed with the address bits named by the physical mode (9, 10, 11 and/or 17). It is combinational in the same cycle.
- R12: Mode codes are NONE=0, 9=1, 9_10=2, 9_11=3, 9_10_11=4, 9_17=5, 9_10_17=6, UNKNOWN=7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_req | output | 1 | High while no configuration has been sampled |
| cfg_valid | input | 1 | Configuration strobe; the inputs below are sampled when it is high |
| cfg_word | input | CW | Memory-configuration word |
| rank_bound0 | input | RW | Top rank boundary, channel 0 |
| rank_bound1 | input | RW | Top rank boundary, channel 1 |
| platform | input | 2 | Platform class |
| tiling | input | 2 | Requested tiling mode |
| stride_in | input | SW | Requested stride |
| addr_in | input | AW | Byte address to swizzle |
| mode_x | output | 3 | Registered X-tiling mode |
| mode_y | output | 3 | Registered Y-tiling mode |
| eff_tiling | output | 2 | Tiling after fallback |
| eff_stride | output | SW | Stride after fallback |
| applied_mode | output | 3 | Physical mode applied to the address |
| user_mode | output | 3 | User-visible mode with bit 17 hidden |
| addr_out | output | AW | Swizzled address |

## Verification
Only the detected modes and `cfg_req` have a latency: they are due one clock edge after the strobe. Every other output follows the present inputs and the registered modes in the same cycle. The bench drives inputs just after each rising edge and updates its reference model on the same rising edge as the design. It compares every output at the following falling edge, so the registered results are checked exactly one cycle after the strobe and the combinational ones in the cycle they are requested. Configuration inputs are also changed without a strobe, and the modes are then checked for any change.

// File: rtl/swz_pkg.sv
package swz_pkg;

    typedef enum logic [2:0] {
        SWZ_NONE     = 3'd0,
        SWZ_9        = 3'd1,
        SWZ_9_10     = 3'd2,
        SWZ_9_11     = 3'd3,
        SWZ_9_10_11  = 3'd4,
        SWZ_9_17     = 3'd5,
        SWZ_9_10_17  = 3'd6,
        SWZ_UNKNOWN  = 3'd7
    } swz_mode_e;

    typedef enum logic [1:0] {
        PLAT_LEGACY = 2'd0,
        PLAT_MOBILE = 2'd1,
        PLAT_FLEX   = 2'd2,
        PLAT_FIXED  = 2'd3
    } plat_e;

    typedef enum logic [1:0] {
        TILE_LINEAR = 2'd0,
        TILE_X      = 2'd1,
        TILE_Y      = 2'd2,
        TILE_RSVD   = 2'd3
    } tile_e;

    typedef enum logic [1:0] {
        CH_SINGLE = 2'd0,
        CH_ASYM   = 2'd1,
        CH_INTLV  = 2'd2,
        CH_RSVD   = 2'd3
    } chan_e;

    // Field positions inside the memory-configuration word
    localparam int CFG_CHAN_LSB = 0;
    localparam int CFG_HI_SEL   = 9;   // 1: CPU folds bit 17, 0: bit 11
    localparam int CFG_XOR_OFF  = 10;  // 1: CPU channel XOR disabled

    // Address bits that may fold into bit 6
    localparam int TAP_DST = 6;
    localparam int TAP_A   = 9;
    localparam int TAP_B   = 10;
    localparam int TAP_C   = 11;
    localparam int TAP_D   = 17;

    typedef struct packed {
        swz_mode_e x;
        swz_mode_e y;
    } swz_pair_t;

    typedef struct packed {
        logic a;   // bit 9
        logic b;   // bit 10
        logic c;   // bit 11
        logic d;   // bit 17
    } swz_taps_t;

    localparam swz_pair_t PAIR_NONE = '{x: SWZ_NONE,    y: SWZ_NONE};
    localparam swz_pair_t PAIR_BASE = '{x: SWZ_9_10,    y: SWZ_9};
    localparam swz_pair_t PAIR_UNK  = '{x: SWZ_UNKNOWN, y: SWZ_UNKNOWN};

    // Mode seen by software: the bit-17 term is handled elsewhere
    function automatic swz_mode_e swz_user_view(swz_mode_e m);
        case (m)
            SWZ_9_17:    return SWZ_9;
            SWZ_9_10_17: return SWZ_9_10;
            default:     return m;
        endcase
    endfunction

    // XOR contribution folded into bit 6 for a given mode
    function automatic logic swz_fold(swz_mode_e m, swz_taps_t t);
        case (m)
            SWZ_9:       return t.a;
            SWZ_9_10:    return t.a ^ t.b;
            SWZ_9_11:    return t.a ^ t.c;
            SWZ_9_10_11: return t.a ^ t.b ^ t.c;
            SWZ_9_17:    return t.a ^ t.d;
            SWZ_9_10_17: return t.a ^ t.b ^ t.d;
            default:     return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/swz_mode_detect.sv
module swz_mode_detect
    import swz_pkg::*;
#(
    parameter int CW = 32,
    parameter int RW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_valid,
    input  logic [CW-1:0] cfg_word,
    input  logic [RW-1:0] rank_bound0,
    input  logic [RW-1:0] rank_bound1,
    input  plat_e         platform,
    output swz_pair_t     modes_q,
    output logic          configured_q
);

    localparam logic [CW-1:0] ALL_ONES = {CW{1'b1}};

    chan_e     chan;
    logic      xor_off;
    logic      hi_sel;
    swz_pair_t mobile_pair;
    swz_pair_t next_pair;

    assign chan    = chan_e'(cfg_word[CFG_CHAN_LSB +: 2]);
    assign xor_off = cfg_word[CFG_XOR_OFF];
    assign hi_sel  = cfg_word[CFG_HI_SEL];

    always_comb begin
        mobile_pair = PAIR_UNK;
        if (cfg_word == ALL_ONES) begin
            mobile_pair = PAIR_UNK;
        end else begin
            case (chan)
                CH_SINGLE, CH_ASYM: mobile_pair = PAIR_NONE;
                CH_INTLV: begin
                    if (xor_off)
                        mobile_pair = PAIR_BASE;
                    else if (!hi_sel)
                        mobile_pair = '{x: SWZ_9_10_11, y: SWZ_9_11};
                    else
                        mobile_pair = '{x: SWZ_9_10_17, y: SWZ_9_17};
                end
                default:            mobile_pair = PAIR_UNK;
            endcase
        end
    end

    always_comb begin
        case (platform)
            PLAT_LEGACY: next_pair = PAIR_NONE;
            PLAT_MOBILE: next_pair = mobile_pair;
            PLAT_FLEX:   next_pair = (rank_bound0 == rank_bound1) ? PAIR_BASE : PAIR_NONE;
            default:     next_pair = PAIR_BASE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            modes_q      <= PAIR_UNK;
            configured_q <= 1'b0;
        end else if (cfg_valid) begin
            modes_q      <= next_pair;
            configured_q <= 1'b1;
        end
    end

endmodule

// File: rtl/swz_tile_resolve.sv
module swz_tile_resolve
    import swz_pkg::*;
#(
    parameter int SW = 16
) (
    input  tile_e         tiling,
    input  swz_pair_t     modes,
    input  logic [SW-1:0] stride_in,
    output tile_e         eff_tiling,
    output logic [SW-1:0] eff_stride,
    output swz_mode_e     phys_mode,
    output swz_mode_e     user_mode
);

    swz_mode_e raw;

    always_comb begin
        raw = SWZ_NONE;
        case (tiling)
            TILE_X:  raw = modes.x;
            TILE_Y:  raw = modes.y;
            default: raw = SWZ_NONE;
        endcase
    end

    always_comb begin
        if (tiling == TILE_X || tiling == TILE_Y) begin
            if (raw == SWZ_UNKNOWN) begin
                eff_tiling = TILE_LINEAR;
                eff_stride = '0;
                phys_mode  = SWZ_NONE;
            end else begin
                eff_tiling = tiling;
                eff_stride = stride_in;
                phys_mode  = raw;
            end
        end else begin
            eff_tiling = TILE_LINEAR;
            eff_stride = '0;
            phys_mode  = SWZ_NONE;
        end
        user_mode = swz_user_view(phys_mode);
    end

endmodule

// File: rtl/swz_addr_xor.sv
module swz_addr_xor
    import swz_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr_in,
    input  swz_mode_e     mode,
    output logic [AW-1:0] addr_out
);

    localparam int TOP_TAP = TAP_D;

    swz_taps_t taps;
    logic      fold;

    generate
        if (AW > TOP_TAP) begin : g_full
            assign taps = '{a: addr_in[TAP_A], b: addr_in[TAP_B],
                            c: addr_in[TAP_C], d: addr_in[TAP_D]};
        end else begin : g_narrow
            assign taps = '{a: addr_in[TAP_A], b: addr_in[TAP_B],
                            c: addr_in[TAP_C], d: 1'b0};
        end
    endgenerate

    assign fold = swz_fold(mode, taps);

    always_comb begin
        addr_out          = addr_in;
        addr_out[TAP_DST] = addr_in[TAP_DST] ^ fold;
    end

endmodule

// File: rtl/tiled_addr_swizzler.sv
module tiled_addr_swizzler
    import swz_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 32,
    parameter int RW = 16,
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst,
    output logic          cfg_req,
    input  logic          cfg_valid,
    input  logic [CW-1:0] cfg_word,
    input  logic [RW-1:0] rank_bound0,
    input  logic [RW-1:0] rank_bound1,
    input  logic [1:0]    platform,
    input  logic [1:0]    tiling,
    input  logic [SW-1:0] stride_in,
    input  logic [AW-1:0] addr_in,
    output logic [2:0]    mode_x,
    output logic [2:0]    mode_y,
    output logic [1:0]    eff_tiling,
    output logic [SW-1:0] eff_stride,
    output logic [2:0]    applied_mode,
    output logic [2:0]    user_mode,
    output logic [AW-1:0] addr_out
);

    swz_pair_t modes_q;
    logic      configured_q;
    tile_e     eff_tile_e;
    swz_mode_e phys_e;
    swz_mode_e user_e;

    swz_mode_detect #(.CW(CW), .RW(RW)) u_detect (
        .clk          (clk),
        .rst          (rst),
        .cfg_valid    (cfg_valid),
        .cfg_word     (cfg_word),
        .rank_bound0  (rank_bound0),
        .rank_bound1  (rank_bound1),
        .platform     (plat_e'(platform)),
        .modes_q      (modes_q),
        .configured_q (configured_q)
    );

    swz_tile_resolve #(.SW(SW)) u_resolve (
        .tiling     (tile_e'(tiling)),
        .modes      (modes_q),
        .stride_in  (stride_in),
        .eff_tiling (eff_tile_e),
        .eff_stride (eff_stride),
        .phys_mode  (phys_e),
        .user_mode  (user_e)
    );

    swz_addr_xor #(.AW(AW)) u_xor (
        .addr_in  (addr_in),
        .mode     (phys_e),
        .addr_out (addr_out)
    );

    assign cfg_req      = !configured_q;
    assign mode_x       = modes_q.x;
    assign mode_y       = modes_q.y;
    assign eff_tiling   = eff_tile_e;
    assign applied_mode = phys_e;
    assign user_mode    = user_e;

endmodule

// File: rtl/swz_checker.sv
module swz_checker #(
    parameter int AW = 32,
    parameter int SW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          cfg_req,
    input logic          cfg_valid,
    input logic [1:0]    tiling,
    input logic [2:0]    mode_x,
    input logic [2:0]    mode_y,
    input logic [1:0]    eff_tiling,
    input logic [SW-1:0] eff_stride,
    input logic [2:0]    applied_mode,
    input logic [2:0]    user_mode,
    input logic [AW-1:0] addr_in,
    input logic [AW-1:0] addr_out
);

    localparam logic [AW-1:0] KEEP_MASK = ~({{(AW-1){1'b0}}, 1'b1} << 6);

    assert_hold_x_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(cfg_valid) |-> $stable(mode_x));
    assert_hold_y_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(cfg_valid) |-> $stable(mode_y));
    assert_req_drop_R2: assert property (@(posedge clk) disable iff (rst)
        cfg_valid |=> !cfg_req);
    assert_linear_pass_R8: assert property (@(posedge clk) disable iff (rst)
        (tiling == 2'd0 || tiling == 2'd3) |-> (addr_out == addr_in && user_mode == 3'd0 && eff_stride == '0));
    assert_unknown_fallback_R9: assert property (@(posedge clk) disable iff (rst)
        ((tiling == 2'd1 && mode_x == 3'd7) || (tiling == 2'd2 && mode_y == 3'd7))
        |-> (eff_tiling == 2'd0 && eff_stride == '0 && applied_mode == 3'd0));
    assert_user_hides17_R10: assert property (@(posedge clk) disable iff (rst)
        user_mode != 3'd5 && user_mode != 3'd6 && user_mode != 3'd7);
    assert_addr_bit6_only_R11: assert property (@(posedge clk) disable iff (rst)
        ((addr_out ^ addr_in) & KEEP_MASK) == '0);

endmodule

bind tiled_addr_swizzler swz_checker #(.AW(AW), .SW(SW)) u_swz_checker (
    .clk          (clk),
    .rst          (rst),
    .cfg_req      (cfg_req),
    .cfg_valid    (cfg_valid),
    .tiling       (tiling),
    .mode_x       (mode_x),
    .mode_y       (mode_y),
    .eff_tiling   (eff_tiling),
    .eff_stride   (eff_stride),
    .applied_mode (applied_mode),
    .user_mode    (user_mode),
    .addr_in      (addr_in),
    .addr_out     (addr_out)
);

// File: tb/tiled_addr_swizzler_bench.sv
`timescale 1ns/1ps
module tiled_addr_swizzler_bench;

    localparam int AW = 32;
    localparam int CW = 32;
    localparam int RW = 16;
    localparam int SW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_req;
    logic          cfg_valid = 1'b0;
    logic [CW-1:0] cfg_word = '0;
    logic [RW-1:0] rank_bound0 = '0;
    logic [RW-1:0] rank_bound1 = '0;
    logic [1:0]    platform = '0;
    logic [1:0]    tiling = '0;
    logic [SW-1:0] stride_in = '0;
    logic [AW-1:0] addr_in = '0;
    logic [2:0]    mode_x, mode_y, applied_mode, user_mode;
    logic [1:0]    eff_tiling;
    logic [SW-1:0] eff_stride;
    logic [AW-1:0] addr_out;

    int    vectors = 0;
    int    misses = 0;
    string cur_req = "R1";
    bit    done = 0;

    // reference state
    int ref_x = 7;
    int ref_y = 7;
    bit ref_cfgd = 0;

    always #2.5 clk = ~clk;

    tiled_addr_swizzler #(.AW(AW), .CW(CW), .RW(RW), .SW(SW)) u_tiled_addr_swizzler (
        .clk(clk), .rst(rst), .cfg_req(cfg_req), .cfg_valid(cfg_valid),
        .cfg_word(cfg_word), .rank_bound0(rank_bound0), .rank_bound1(rank_bound1),
        .platform(platform), .tiling(tiling), .stride_in(stride_in), .addr_in(addr_in),
        .mode_x(mode_x), .mode_y(mode_y), .eff_tiling(eff_tiling), .eff_stride(eff_stride),
        .applied_mode(applied_mode), .user_mode(user_mode), .addr_out(addr_out)
    );

    // Behavioural decode from the requirements: returns {x, y} as x*8+y
    function automatic int ref_decode(int plat, logic [CW-1:0] w, int r0, int r1);
        int ch;
        if (plat == 0) return 0 * 8 + 0;                    // R3
        if (plat == 3) return 2 * 8 + 1;                    // R3
        if (plat == 2) return (r0 == r1) ? (2 * 8 + 1) : 0; // R7
        if (w == {CW{1'b1}}) return 7 * 8 + 7;              // R6
        ch = int'(w[1:0]);
        if (ch == 0 || ch == 1) return 0;                   // R4
        if (ch == 3) return 7 * 8 + 7;                      // R4
        if (w[10]) return 2 * 8 + 1;                        // R5
        if (!w[9]) return 4 * 8 + 3;
        return 6 * 8 + 5;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            ref_x = 7; ref_y = 7; ref_cfgd = 0;
        end else if (cfg_valid) begin
            int d;
            d = ref_decode(int'(platform), cfg_word, int'(rank_bound0), int'(rank_bound1));
            ref_x = d / 8; ref_y = d % 8; ref_cfgd = 1;
        end
    end

    task automatic cmp(string tag, string what, longint act, longint exp);
        if (act != exp) begin
            misses++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Compare every output on every falling edge
    always @(negedge clk) begin
        if (!done) begin
            int raw, e_tile, e_mode, e_user, e_str, fold;
            logic [AW-1:0] e_addr;
            string ttag;
            vectors++;
            cmp(cur_req, "cfg_req (R1/R2)", cfg_req, !ref_cfgd);
            cmp({cur_req, " R12"}, "mode_x", mode_x, ref_x);
            cmp({cur_req, " R12"}, "mode_y", mode_y, ref_y);
            raw = (tiling == 1) ? ref_x : (tiling == 2) ? ref_y : 0;
            if (tiling == 0 || tiling == 3) begin
                ttag = "R8"; e_tile = 0; e_mode = 0; e_str = 0;
            end else if (raw == 7) begin
                ttag = "R9"; e_tile = 0; e_mode = 0; e_str = 0;
            end else begin
                ttag = "R10"; e_tile = int'(tiling); e_mode = raw; e_str = int'(stride_in);
            end
            e_user = (e_mode == 5) ? 1 : (e_mode == 6) ? 2 : e_mode;
            fold = 0;
            if (e_mode >= 1 && e_mode <= 6) fold = addr_in[9];
            if (e_mode == 2 || e_mode == 4 || e_mode == 6) fold = fold ^ addr_in[10];
            if (e_mode == 3 || e_mode == 4) fold = fold ^ addr_in[11];
            if (e_mode == 5 || e_mode == 6) fold = fold ^ addr_in[17];
            e_addr = addr_in;
            e_addr[6] = addr_in[6] ^ fold[0];
            cmp(ttag, "eff_tiling", eff_tiling, e_tile);
            cmp(ttag, "eff_stride", eff_stride, e_str);
            cmp(ttag, "applied_mode", applied_mode, e_mode);
            cmp("R10", "user_mode", user_mode, e_user);
            cmp("R11", "addr_out", addr_out, e_addr);
        end
    end

    task automatic traffic(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            tiling    = 2'(i % 4);
            addr_in   = $urandom;
            stride_in = SW'($urandom);
        end
    endtask

    task automatic load_cfg(int plat, logic [CW-1:0] w, int r0, int r1, string tag);
        @(posedge clk); #1;
        cur_req     = tag;
        platform    = 2'(plat);
        cfg_word    = w;
        rank_bound0 = RW'(r0);
        rank_bound1 = RW'(r1);
        cfg_valid   = 1'b1;
        @(posedge clk); #1;
        cfg_valid   = 1'b0;
        traffic(24);
    endtask

    initial begin
        // R1: reset state, tiled traffic before configuration
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        traffic(12);
        load_cfg(0, 32'h0000_0402, 5, 5, "R3");          // legacy
        load_cfg(3, 32'hFFFF_FFFF, 1, 2, "R3");          // fixed
        load_cfg(1, 32'h0000_0000, 0, 0, "R4");          // single channel
        load_cfg(1, 32'h0000_0001, 0, 0, "R4");          // asymmetric
        load_cfg(1, 32'h0000_0003, 0, 0, "R4");          // reserved code
        load_cfg(1, 32'h0000_0402, 0, 0, "R5");          // xor off
        load_cfg(1, 32'h0000_0002, 0, 0, "R5");          // bit 11 term
        load_cfg(1, 32'h0000_0202, 0, 0, "R5");          // bit 17 term
        // R2: configuration inputs change without a strobe
        @(posedge clk); #1;
        cur_req = "R2";
        platform = 2'd2; rank_bound0 = 16'd3; rank_bound1 = 16'd9; cfg_word = '1;
        traffic(16);
        load_cfg(1, 32'hFFFF_FFFF, 0, 0, "R6");          // all ones
        load_cfg(2, 32'h0000_0000, 16'h0400, 16'h0400, "R7");
        load_cfg(2, 32'h0000_0402, 16'h0400, 16'h0200, "R7");
        load_cfg(1, 32'h0000_0202, 0, 0, "R11");
        @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        misses++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule